// File: doc/BRIEF.md
# Exclusive Access Lock Register

This block is a hardware semaphore attached to one access-control descriptor (a memory slot, a memory region or a peripheral). Any domain can claim the protected resource by writing the acquire code into the lock field. Every write carries the ID of the domain that issues it. Software learns whether it won by reading back the owner field and comparing it with its own ID. A blocking acquire repeats the write until the two match.

The owner gives the resource back with a release write. A domain that does not own the lock can still free it with a two-write unlock sequence. The lock can also be shut off for good: once disabled, it stays that way until reset.

The block reports its state and owner on a read port. It also gives the access checker a per-domain verdict, so that while the lock is held only the owner passes.

The lock field is a 3-bit code written to descriptor word 1 (`wr_sel`=1). These code values are used:

| Code | Meaning |
|------|---------|
| 0 | no change |
| 1 | disable |
| 2 | release / enable |
| 3 | acquire |
| 5 | force step A |
| 6 | force step B |

Any other code changes nothing. Writes to word 0 (`wr_sel`=0) never change the lock.

The state reads back as 2 bits:

| Value | State |
|-------|-------|
| 0 | not enabled |
| 1 | free |
| 2 | held |
| 3 | disabled |

Every effect appears on the read port one clock after the write.

Top module: `xlock_reg`

## Requirements
- R1: After reset the state reads 0 (not enabled), the owner reads 0 and `chk_ok` is 1 for every domain.
- R2: Writing code 2 while the state is 0 moves it to 1 (free). Writing code 3 while the state is 0 is ignored.
- R3: Writing code 3 while the state is 1 moves it to 2 (held) and loads the writer's domain ID into the owner field.
- R4: Writing code 3 while the state is 2 leaves the state and the owner unchanged, whoever writes it.
- R5: Writing code 2 while the state is 2 moves it to 1 with owner 0, but only when the writer is the owner. A code-2 write from any other domain is ignored.
- R6: A code-5 write followed by a code-6 write as the very next write, from any domains, frees a held lock (state 1, owner 0). Idle cycles between the two writes are allowed.
- R7: Any other write between the code-5 and code-6 writes cancels the sequence. This includes a code-0 write and a word-0 write. A code-6 write that is not directly preceded by a code-5 write has no effect.
- R8: Writing code 1 in state 0, 1 or 2 moves the state to 3 (disabled) with owner 0. State 3 ignores every write until reset.
- R9: A write of code 0 to word 1, or any write to word 0, leaves the state and the owner unchanged.
- R10: While the state is 2, `chk_ok` is 1 only when `chk_dom` equals the owner. In every other state, `chk_ok` is 1 for every domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Descriptor word written: 1 = lock word, 0 = owner word |
| wr_code | input | 3 | Lock code (used only when `wr_sel`=1) |
| wr_dom | input | DOM_W | Domain ID of the writer |
| chk_dom | input | DOM_W | Domain asking the access checker |
| rd_state | output | 2 | Lock state |
| rd_owner | output | DOM_W | Owner domain (0 unless held) |
| chk_ok | output | 1 | Lock permits `chk_dom` to access the resource |

## Verification
A wrong internal state shows on `rd_state` and `rd_owner` one clock after the write that caused it. The bench compares both of these every cycle, so such a fault surfaces at once.

The hidden arming bit of the forced release cannot be read directly. A fault in it shows only on the following code-6 write, as a lock that should have been freed staying held, or the reverse. The bench therefore follows each arming with:
- an immediate code-6 write,
- an interleaved code-0 write,
- an interleaved word-0 write,
- a stray code-6 write.

Checker verdicts are sampled before each edge for both the owner and a non-owner.

// File: rtl/xlock_pkg.sv
package xlock_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        LK_OFF  = 2'd0,
        LK_FREE = 2'd1,
        LK_HELD = 2'd2,
        LK_DEAD = 2'd3
    } lk_state_e;

    localparam logic [CODE_W-1:0] C_NOP  = 3'd0;
    localparam logic [CODE_W-1:0] C_DIS  = 3'd1;
    localparam logic [CODE_W-1:0] C_UNLK = 3'd2;
    localparam logic [CODE_W-1:0] C_LOCK = 3'd3;
    localparam logic [CODE_W-1:0] C_FA   = 3'd5;
    localparam logic [CODE_W-1:0] C_FB   = 3'd6;
endpackage

// File: rtl/xlock_force_seq.sv
module xlock_force_seq
    import xlock_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_code,
    output logic              fire
);
    typedef struct packed {
        logic armed;
    } seq_t;

    seq_t s_d, s_q;
    logic is_a, is_b;

    always_comb begin
        is_a = wr_en && wr_sel && (wr_code == C_FA);
        is_b = wr_en && wr_sel && (wr_code == C_FB);
        fire = s_q.armed && is_b;
        s_d  = s_q;
        // any write re-decides the arming; only step A arms
        if (wr_en) s_d.armed = is_a;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_ARM_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        is_a |=> s_q.armed); // R6
    AST_ABORT_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !is_a) |=> !s_q.armed); // R7
    AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(s_q.armed)); // R6
endmodule

// File: rtl/xlock_fsm.sv
module xlock_fsm
    import xlock_pkg::*;
#(
    parameter int DOM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [CODE_W-1:0] wr_code,
    input  logic [DOM_W-1:0]  wr_dom,
    input  logic              fire,
    output lk_state_e         state,
    output logic [DOM_W-1:0]  owner
);
    typedef struct packed {
        lk_state_e        st;
        logic [DOM_W-1:0] own;
    } lk_t;

    lk_t l_d, l_q;
    logic lw;

    always_comb begin
        lw  = wr_en && wr_sel;
        l_d = l_q;
        if (lw && l_q.st != LK_DEAD) begin
            if (wr_code == C_DIS) begin
                l_d.st  = LK_DEAD;
                l_d.own = '0;
            end else begin
                unique case (l_q.st)
                    LK_OFF:  if (wr_code == C_UNLK) l_d.st = LK_FREE;
                    LK_FREE: if (wr_code == C_LOCK) begin
                        l_d.st  = LK_HELD;
                        l_d.own = wr_dom;
                    end
                    LK_HELD: if (fire || (wr_code == C_UNLK && wr_dom == l_q.own)) begin
                        l_d.st  = LK_FREE;
                        l_d.own = '0;
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) l_q <= '{st: LK_OFF, own: '0};
        else        l_q <= l_d;
    end

    assign state = l_q.st;
    assign owner = l_q.own;

    AST_DEAD_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.st == LK_DEAD) |=> (l_q.st == LK_DEAD)); // R8
    AST_ACQ_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.st == LK_FREE && lw && wr_code == C_LOCK)
        |=> (l_q.st == LK_HELD && l_q.own == $past(wr_dom))); // R3
    AST_HELD_OWNER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.st == LK_HELD && !lw) |=> (l_q.st == LK_HELD && $stable(l_q.own))); // R4
    AST_FOREIGN_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.st == LK_HELD && lw && wr_code == C_UNLK && wr_dom != l_q.own)
        |=> (l_q.st == LK_HELD && $stable(l_q.own))); // R5
    AST_OFF_NO_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (l_q.st == LK_OFF && wr_code != C_UNLK && wr_code != C_DIS)
        |=> (l_q.st == LK_OFF)); // R2
endmodule

// File: rtl/xlock_reg.sv
module xlock_reg
    import xlock_pkg::*;
#(
    parameter int DOM_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [2:0]        wr_code,
    input  logic [DOM_W-1:0]  wr_dom,
    input  logic [DOM_W-1:0]  chk_dom,
    output logic [1:0]        rd_state,
    output logic [DOM_W-1:0]  rd_owner,
    output logic              chk_ok
);
    logic             fire;
    lk_state_e        st;
    logic [DOM_W-1:0] own;

    xlock_force_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_code (wr_code),
        .fire    (fire)
    );

    xlock_fsm #(.DOM_W(DOM_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_code (wr_code),
        .wr_dom  (wr_dom),
        .fire    (fire),
        .state   (st),
        .owner   (own)
    );

    always_comb begin
        rd_state = st;
        rd_owner = own;
        chk_ok   = (st != LK_HELD) || (chk_dom == own);
    end

    AST_OWNER_ZERO_UNHELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_state != 2'd2) |-> (rd_owner == '0)); // R5
    AST_FORCE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && rd_state == 2'd2) |=> (rd_state == 2'd1)); // R6
endmodule

// File: tb/xlock_reg_test.sv
module xlock_reg_test;
    localparam int DW = 4;

    logic clk = 0, rst_n = 0;
    logic wr_en = 0, wr_sel = 0;
    logic [2:0] wr_code = 0;
    logic [DW-1:0] wr_dom = 0, chk_dom = 0;
    logic [1:0] rd_state;
    logic [DW-1:0] rd_owner;
    logic chk_ok;

    int total = 0, bad = 0;
    int m_st = 0, m_own = 0, m_arm = 0;
    int cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;

    xlock_reg #(.DOM_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_code(wr_code), .wr_dom(wr_dom), .chk_dom(chk_dom),
        .rd_state(rd_state), .rd_owner(rd_owner), .chk_ok(chk_ok)
    );

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive after negedge, check checker verdict, model, compare after edge
    task automatic step(bit en, bit sel, int code, int dom, int cdom, string tag);
        int exp_ok, ns, no, na, fire;
        wr_en = en; wr_sel = sel; wr_code = code[2:0];
        wr_dom = dom[DW-1:0]; chk_dom = cdom[DW-1:0];
        #1;
        exp_ok = (m_st != 2 || cdom == m_own) ? 1 : 0;
        chk({tag, " R10 chk_ok"}, int'(chk_ok), exp_ok);
        ns = m_st; no = m_own; na = m_arm; fire = 0;
        if (en) begin
            fire = (m_arm == 1 && sel && code == 6) ? 1 : 0;
            na = (sel && code == 5) ? 1 : 0;
        end
        if (en && sel && m_st != 3) begin
            if (code == 1) begin ns = 3; no = 0; end
            else if (m_st == 0 && code == 2) ns = 1;
            else if (m_st == 1 && code == 3) begin ns = 2; no = dom; end
            else if (m_st == 2 && (fire == 1 || (code == 2 && dom == m_own))) begin
                ns = 1; no = 0;
            end
        end
        @(posedge clk);
        m_st = ns; m_own = no; m_arm = na;
        @(negedge clk);
        chk({tag, " state"}, int'(rd_state), m_st);
        chk({tag, " owner"}, int'(rd_owner), m_own);
    endtask

    task automatic idle(string tag);
        step(0, 0, 0, 0, 0, tag);
    endtask

    task automatic do_reset();
        rst_n = 0; wr_en = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        m_st = 0; m_own = 0; m_arm = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000 && !done) begin
                bad++; total++;
                $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        chk("R1 state", int'(rd_state), 0);
        chk("R1 owner", int'(rd_owner), 0);
        chk("R1 chk_ok", int'(chk_ok), 1);
        // R2 acquire before enable ignored, then enable
        step(1, 1, 3, 4, 4, "R2");
        step(1, 1, 2, 0, 0, "R2");
        // R9 ordinary writes
        step(1, 1, 0, 7, 0, "R9");
        step(1, 0, 3, 7, 0, "R9");
        // R3 acquire
        step(1, 1, 3, 5, 5, "R3");
        step(0, 0, 0, 0, 5, "R10");
        step(0, 0, 0, 0, 9, "R10");
        // R4 acquire by other and by owner
        step(1, 1, 3, 9, 9, "R4");
        step(1, 1, 3, 5, 5, "R4");
        // R5 foreign release ignored, owner release
        step(1, 1, 2, 9, 9, "R5");
        step(1, 1, 2, 5, 5, "R5");
        // R6 force with idle gap
        step(1, 1, 3, 12, 3, "R6");
        step(1, 1, 5, 3, 3, "R6");
        idle("R6");
        idle("R6");
        step(1, 1, 6, 8, 12, "R6");
        // R7 aborted by code 0, by word 0, stray step B
        step(1, 1, 3, 2, 2, "R7");
        step(1, 1, 5, 7, 7, "R7");
        step(1, 1, 0, 7, 7, "R7");
        step(1, 1, 6, 7, 7, "R7");
        step(1, 1, 5, 7, 7, "R7");
        step(1, 0, 0, 7, 7, "R7");
        step(1, 1, 6, 7, 7, "R7");
        step(1, 1, 6, 7, 2, "R7");
        step(1, 1, 5, 1, 1, "R7");
        step(1, 1, 5, 1, 1, "R7");
        step(1, 1, 6, 1, 1, "R6");
        // blocking-style acquire race
        step(1, 1, 3, 6, 6, "R3");
        step(1, 1, 3, 11, 11, "R4");
        // R8 disable while held, then everything ignored
        step(1, 1, 1, 11, 6, "R8");
        step(1, 1, 2, 0, 4, "R8");
        step(1, 1, 3, 4, 4, "R8");
        step(1, 1, 5, 4, 4, "R8");
        step(1, 1, 6, 4, 4, "R8");
        idle("R8");
        // reset clears disable; disable from not-enabled
        do_reset();
        chk("R1 state after reset", int'(rd_state), 0);
        step(1, 1, 1, 3, 3, "R8");
        step(1, 1, 2, 3, 3, "R8");
        do_reset();
        step(1, 1, 2, 0, 0, "R2");
        step(1, 1, 2, 0, 0, "R5");
        step(1, 1, 1, 0, 0, "R8");
        step(1, 1, 2, 0, 0, "R8");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule